// File: doc/BRIEF.md
# Tree-Walking Packet Header Classifier

This block gives a permit or deny verdict for a packet from its 5-tuple header: source IPv4 address, destination IPv4 address, source port, destination port and protocol number. The header arrives as one 104-bit word with a valid/ready handshake. The rule set is compiled offline into a decision tree and stored in an internal rule memory. Each memory word is a 24-bit sub-rule.

Once a header is accepted, a small single-cycle engine walks the tree from rule address 0. In each clock it fetches one sub-rule, picks one header byte, compares it with the sub-rule's constant, and chooses the next address. The walk ends when it reaches a verdict leaf. A step watchdog ends any walk that never reaches a leaf. A plain write port loads the rule memory, and it takes effect only while the engine is idle.

Top module: `pkt_tree_classifier`

## Requirements
- R1: Byte index k (0..12) selects bits [103-8k -: 8] of the latched tuple, so the most significant byte comes first: 0-3 is source IP, 4-7 destination IP, 8-9 source port, 10-11 destination port, 12 protocol.
- R2: A sub-rule holds the byte index in [23:20], the compare constant in [19:12] and the fail-branch address in [11:0]. If the selected byte equals the constant, the next address is the current address plus one; otherwise it is the fail-branch address.
- R3: Exactly one sub-rule is executed per clock. `verdict_valid` is high in the N-th cycle after the accepting clock edge, where N is the number of sub-rules fetched, the leaf included.
- R4: Index 14 is a permit leaf (`verdict_permit`=1). Index 15 is a deny leaf (`verdict_permit`=0). Index 13 is illegal and gives deny.
- R5: A header is latched on a clock edge where `in_valid` and `in_ready` are both high. Every walk starts at address 0. `in_ready` is low and `busy` is high until the verdict is emitted, and changes on `in_tuple` during a walk have no effect.
- R6: A verdict is a one-cycle `verdict_valid` pulse. In that same cycle the engine is already idle again, with `busy` low and `in_ready` high.
- R7: If the MAX_STEPS-th fetched sub-rule (default 4096) is not a leaf, a deny verdict is emitted in its place.
- R8: A rule write (`wr_en`, `wr_addr`, `wr_data`) is stored only while idle, including in the same cycle as a header acceptance, and is then seen by that walk. Writes made while busy are ignored.
- R9: A fetch from an address at or above RULE_DEPTH (default 256) reads as a deny leaf.
- R10: After reset `in_ready`=1, `busy`=0 and `verdict_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Header word offered |
| in_ready | output | 1 | Engine idle and able to accept a header |
| in_tuple | input | 104 | Source IP, destination IP, source port, destination port, protocol (MSB first) |
| wr_en | input | 1 | Rule memory write strobe |
| wr_addr | input | RULE_AW (8) | Rule memory write address |
| wr_data | input | 24 | Sub-rule word to store |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_permit | output | 1 | 1 = permit, 0 = deny, qualified by `verdict_valid` |
| busy | output | 1 | A walk is in progress |

## Verification
A rule write and a header acceptance can occur in the same idle cycle. The bench provokes this by driving `wr_en`, rewriting address 0 as a permit leaf, together with `in_valid`, and it expects a one-cycle permit verdict. That result shows the write landed before the first fetch. The opposite overlap is also tested: a write issued while a walk is running must leave the verdict unchanged, and a later walk must show that the old rule is still in memory.

// File: rtl/pcls_pkg.sv
// Shared sizes, sub-rule layout and leaf codes for the tree-walking classifier.
// Assumes a 104-bit tuple split into 13 bytes, most significant byte first.
package pcls_pkg;
    localparam int TUPLE_W  = 104;
    localparam int N_BYTES  = TUPLE_W / 8;
    localparam int RULE_W   = 24;
    localparam int IDX_W    = 4;
    localparam int BR_W     = 12;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [7:0]       cmp;
        logic [BR_W-1:0]  fail;
    } subrule_t;

    localparam logic [IDX_W-1:0] IDX_ILLEGAL = 4'd13;
    localparam logic [IDX_W-1:0] IDX_PERMIT  = 4'd14;
    localparam logic [IDX_W-1:0] IDX_DENY    = 4'd15;

    typedef enum logic { ST_IDLE = 1'b0, ST_WALK = 1'b1 } walk_state_t;
endpackage

// File: rtl/pcls_rule_mem.sv
// Rule store: synchronous write, combinational read.
// Addresses at or above DEPTH read as a deny leaf. Assumes DEPTH <= 2**BR_W.
module pcls_rule_mem
    import pcls_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [RULE_W-1:0] wr_data,
    input  logic [BR_W-1:0]   rd_addr,
    output subrule_t          rd_rule
);
    logic [RULE_W-1:0] mem [DEPTH];

    // store a sub-rule when the controller grants the write
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // fetch within the same cycle; out-of-range addresses give a deny leaf
    always_comb begin
        if (int'(rd_addr) < DEPTH) rd_rule = subrule_t'(mem[rd_addr[AW-1:0]]);
        else                       rd_rule = '{idx: IDX_DENY, cmp: 8'h00, fail: '0};
    end
endmodule

// File: rtl/pcls_byte_sel.sv
// Picks one header byte by index, with index 0 at the most significant byte.
// Indices beyond the tuple return zero; the controller treats them as leaves.
module pcls_byte_sel
    import pcls_pkg::*;
(
    input  logic [TUPLE_W-1:0] tuple,
    input  logic [IDX_W-1:0]   idx,
    output logic [7:0]         sel_byte
);
    logic [7:0] lanes [N_BYTES];

    for (genvar k = 0; k < N_BYTES; k++) begin : g_lane
        assign lanes[k] = tuple[TUPLE_W-1-8*k -: 8];
    end

    // route the addressed lane to the comparator
    always_comb begin
        sel_byte = 8'h00;
        for (int k = 0; k < N_BYTES; k++) begin
            if (int'(idx) == k) sel_byte = lanes[k];
        end
    end
endmodule

// File: rtl/pcls_step_ctr.sv
// Counts the sub-rules executed in one walk.
// `last` flags the MAX_STEPS-th fetch. Assumes MAX_STEPS >= 2.
module pcls_step_ctr #(
    parameter int MAX_STEPS = 4096,
    localparam int CW       = $clog2(MAX_STEPS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    logic [CW-1:0] count;

    // restart on each new walk, advance once per executed non-final step
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (step)  count <= count + 1'b1;
    end

    assign last = (int'(count) == MAX_STEPS - 1);
endmodule

// File: rtl/pkt_tree_classifier.sv
// Permit/deny classifier that walks a decision tree of 24-bit sub-rules.
// Each clock it fetches one sub-rule, compares one header byte and branches,
// until it reaches a leaf or the step limit. Rule writes apply only when idle.
module pkt_tree_classifier
    import pcls_pkg::*;
#(
    parameter int RULE_DEPTH = 256,
    parameter int MAX_STEPS  = 4096,
    localparam int RULE_AW   = $clog2(RULE_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [TUPLE_W-1:0] in_tuple,
    input  logic               wr_en,
    input  logic [RULE_AW-1:0] wr_addr,
    input  logic [RULE_W-1:0]  wr_data,
    output logic               verdict_valid,
    output logic               verdict_permit,
    output logic               busy
);
    walk_state_t        state;
    logic [TUPLE_W-1:0] hdr;
    logic [BR_W-1:0]    pc;
    subrule_t           rule;
    logic [7:0]         cur_byte;
    logic               is_leaf, hit, wd_last, accept, finish;

    assign in_ready = (state == ST_IDLE);
    assign busy     = (state == ST_WALK);
    assign accept   = in_valid && in_ready;

    pcls_rule_mem #(.DEPTH(RULE_DEPTH)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en && in_ready),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (pc),
        .rd_rule (rule)
    );

    pcls_byte_sel u_sel (
        .tuple    (hdr),
        .idx      (rule.idx),
        .sel_byte (cur_byte)
    );

    pcls_step_ctr #(.MAX_STEPS(MAX_STEPS)) u_steps (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  (busy && !finish),
        .last  (wd_last)
    );

    // decode the fetched sub-rule for this cycle
    always_comb begin
        is_leaf = (rule.idx >= IDX_ILLEGAL);
        hit     = (cur_byte == rule.cmp);
        finish  = busy && (is_leaf || wd_last);
    end

    // walk controller: latch header, step the tree, emit verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= ST_IDLE;
            hdr            <= '0;
            pc             <= '0;
            verdict_valid  <= 1'b0;
            verdict_permit <= 1'b0;
        end else begin
            verdict_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        hdr   <= in_tuple;
                        pc    <= '0;
                        state <= ST_WALK;
                    end
                end
                ST_WALK: begin
                    if (finish) begin
                        verdict_valid  <= 1'b1;
                        verdict_permit <= is_leaf && (rule.idx == IDX_PERMIT);
                        state          <= ST_IDLE;
                    end else begin
                        pc <= hit ? pc + 1'b1 : rule.fail;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pcls_checker.sv
// Temporal checks on the classifier ports, attached by bind.
module pcls_checker #(
    parameter int MAX_STEPS = 4096
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic verdict_valid,
    input logic busy
);
    int busy_run;

    // length of the current busy stretch
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    AST_ACCEPT_STARTS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);                                    // R5
    AST_NO_READY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);                                                 // R5
    AST_VERDICT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid);                                   // R6
    AST_VERDICT_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> ($past(busy) && !busy && in_ready));               // R6
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= MAX_STEPS);                                              // R7
endmodule

bind pkt_tree_classifier pcls_checker #(.MAX_STEPS(MAX_STEPS)) u_pcls_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .verdict_valid (verdict_valid),
    .busy          (busy)
);

// File: tb/pkt_tree_classifier_bench.sv
// Directed bench for the tree-walking classifier: one task per scenario.
module pkt_tree_classifier_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;
    localparam int STEPS      = 4096;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [103:0] in_tuple = '0;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_addr = '0;
    logic [23:0]  wr_data = '0;
    logic         verdict_valid, verdict_permit, busy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int t0    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pkt_tree_classifier #(.RULE_DEPTH(DEPTH), .MAX_STEPS(STEPS)) u_pkt_tree_classifier (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tuple(in_tuple), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .verdict_valid(verdict_valid), .verdict_permit(verdict_permit), .busy(busy)
    );

    function automatic logic [23:0] sr(input int idx, input int cmp, input int fail);
        return {idx[3:0], cmp[7:0], fail[11:0]};
    endfunction

    function automatic logic [103:0] mk_tuple(input logic [31:0] sip, input logic [31:0] dip,
                                              input logic [15:0] sp, input logic [15:0] dp,
                                              input logic [7:0] pr);
        return {sip, dip, sp, dp, pr};
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_rule(input int addr, input logic [23:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr[7:0]; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // offer a header; optionally write a rule in the same cycle
    task automatic send_hdr(input logic [103:0] t, input logic do_wr,
                            input int waddr, input logic [23:0] wdata);
        @(negedge clk);
        in_valid = 1'b1; in_tuple = t;
        wr_en = do_wr; wr_addr = waddr[7:0]; wr_data = wdata;
        t0 = cyc + 1;
        @(negedge clk);
        in_valid = 1'b0; wr_en = 1'b0;
        in_tuple = ~t;
    endtask

    task automatic wait_verdict(input logic exp_permit, input int exp_lat, input string tag);
        int guard = 0;
        while (!verdict_valid && guard < STEPS + 50) begin
            check(!in_ready && busy, {tag, " R5 busy/ready"}, in_ready, 0);
            n_chk--;
            @(negedge clk);
            guard++;
        end
        check(verdict_valid, {tag, " R3 verdict arrives"}, verdict_valid, 1);
        check(cyc - t0 == exp_lat, {tag, " R3 latency"}, cyc - t0, exp_lat);
        check(verdict_permit == exp_permit, {tag, " R4 verdict"}, verdict_permit, exp_permit);
        check(in_ready && !busy, {tag, " R6 idle with verdict"}, in_ready, 1);
        @(negedge clk);
        check(!verdict_valid, {tag, " R6 single pulse"}, verdict_valid, 0);
    endtask

    task automatic t_reset;
        check(in_ready && !busy && !verdict_valid, "R10 reset state",
              {in_ready, busy, verdict_valid}, 3'b100);
    endtask

    task automatic load_tree;
        write_rule(0, sr(0, 8'h0A, 5));
        write_rule(1, sr(12, 6, 5));
        write_rule(2, sr(10, 8'h00, 5));
        write_rule(3, sr(11, 8'h50, 5));
        write_rule(4, sr(14, 0, 0));
        write_rule(5, sr(12, 17, 7));
        write_rule(6, sr(14, 0, 0));
        write_rule(7, sr(15, 0, 0));
    endtask

    task automatic t_tree_walks;
        load_tree();
        send_hdr(mk_tuple(32'h0A000001, 32'hC0A80001, 16'd1234, 16'd80, 8'd6), 1'b0, 0, '0);
        wait_verdict(1'b1, 5, "R2 tcp/80 permit");
        send_hdr(mk_tuple(32'h0A000001, 32'hC0A80001, 16'd1234, 16'd81, 8'd6), 1'b0, 0, '0);
        wait_verdict(1'b0, 6, "R2 tcp/81 deny");
        send_hdr(mk_tuple(32'h0B000001, 32'h01020304, 16'd53, 16'd53, 8'd17), 1'b0, 0, '0);
        wait_verdict(1'b1, 3, "R2 udp permit");
        send_hdr(mk_tuple(32'h0B000001, 32'h01020304, 16'd0, 16'd0, 8'd1), 1'b0, 0, '0);
        wait_verdict(1'b0, 3, "R2 icmp deny");
    endtask

    task automatic t_byte_map;
        logic [103:0] t;
        for (int k = 0; k < 13; k++) t[103-8*k -: 8] = 8'hA0 + k[7:0];
        write_rule(1, sr(14, 0, 0));
        write_rule(2, sr(15, 0, 0));
        for (int k = 0; k < 13; k++) begin
            write_rule(0, sr(k, 8'hA0 + k, 2));
            send_hdr(t, 1'b0, 0, '0);
            wait_verdict(1'b1, 2, $sformatf("R1 byte %0d match", k));
            write_rule(0, sr(k, (8'hA0 + k) ^ 8'h01, 2));
            send_hdr(t, 1'b0, 0, '0);
            wait_verdict(1'b0, 2, $sformatf("R1 byte %0d miss", k));
        end
    endtask

    task automatic t_leaf_codes;
        write_rule(0, sr(13, 0, 0));
        send_hdr('0, 1'b0, 0, '0);
        wait_verdict(1'b0, 1, "R4 illegal index 13");
        write_rule(0, sr(15, 0, 0));
        send_hdr('0, 1'b0, 0, '0);
        wait_verdict(1'b0, 1, "R4 deny leaf");
        write_rule(0, sr(14, 0, 0));
        send_hdr('0, 1'b0, 0, '0);
        wait_verdict(1'b1, 1, "R4 permit leaf");
    endtask

    task automatic t_out_of_range;
        write_rule(0, sr(0, 8'hFF, 300));
        send_hdr('0, 1'b0, 0, '0);
        wait_verdict(1'b0, 2, "R9 branch past depth");
    endtask

    task automatic t_write_with_accept;
        write_rule(0, sr(15, 0, 0));
        send_hdr('0, 1'b1, 0, sr(14, 0, 0));
        wait_verdict(1'b1, 1, "R8 write in accept cycle");
    endtask

    task automatic t_write_while_busy;
        load_tree();
        send_hdr(mk_tuple(32'h0A000001, 32'h0, 16'd0, 16'd80, 8'd6), 1'b0, 0, '0);
        wr_en = 1'b1; wr_addr = 8'd4; wr_data = sr(15, 0, 0);
        @(negedge clk);
        wr_en = 1'b0;
        wait_verdict(1'b1, 5, "R8 busy write ignored");
        send_hdr(mk_tuple(32'h0A000001, 32'h0, 16'd0, 16'd80, 8'd6), 1'b0, 0, '0);
        wait_verdict(1'b1, 5, "R8 rule unchanged after busy write");
    endtask

    task automatic t_watchdog;
        write_rule(0, sr(0, 8'hFF, 0));
        send_hdr('0, 1'b0, 0, '0);
        wait_verdict(1'b0, STEPS, "R7 looping tree denied");
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tree_walks();
        t_byte_map();
        t_leaf_codes();
        t_out_of_range();
        t_write_with_accept();
        t_write_while_busy();
        t_watchdog();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end
endmodule